// File: doc/BRIEF.md
# I2C Target Address Filter

This block sits beside the byte engine of an I2C target controller and decides whether the current transfer is addressed to it. The byte engine gives it three things: a one-cycle pulse for every START or repeated START, and a one-cycle strobe with each byte it shifts in. The block compares the first one or two bytes of every frame against a parameterised bank of filter slots. Software programs each slot over APB with an address, an enable and a choice of 7-bit or 10-bit matching.

Each slot that matches sets its own bit in a hit bitmap. Software reads the bitmap over APB. The OR of the bitmap is a level output. The controller uses that level to hold SCL low in the acknowledge slot until software has queued its reply. The bitmap is cleared at every START or repeated START, so it always describes the frame in progress. The compare uses the slot contents held at the edge where the byte is taken.

Top module: `i2c_addr_filter`

## Requirements
- R1: After reset every filter register reads 0, the hit bitmap reads 0 and `hit_any` is 0.
- R2: Filter slot i sits at APB offset 136 + 4*i. Write data bit 15 is the enable, bit 14 selects 10-bit mode and bits 9:0 hold the address. A read returns these same fields in the same positions, and every other bit reads 0.
- R3: The hit bitmap reads at offset 128, with bit i belonging to slot i and all higher bits 0. A write to offset 128 leaves the bitmap unchanged.
- R4: An enabled 7-bit slot hits when the first byte after a START has bits 7:1 equal to its address bits 6:0. Byte bit 0 (read/write) is ignored.
- R5: An enabled 10-bit slot is armed by a first byte whose bits 7:3 are 11110 and whose bits 2:1 equal address bits 9:8. It hits when the second byte equals address bits 7:0. The first byte alone sets no hit.
- R6: A 10-bit first byte followed by a non-matching second byte sets no hit. A first byte that matches no 7-bit slot sets no hit.
- R7: A disabled slot never sets its hit bit.
- R8: A START clears the bitmap. When a START and a byte strobe fall in the same cycle, the START wins and that byte is discarded.
- R9: Bytes taken before the first START after reset, and bytes after the second byte of a frame, never change the bitmap.
- R10: `hit_any` is 1 exactly when at least one bitmap bit is set.
- R11: When an APB write to a slot and a byte strobe fall in the same cycle, the compare uses the slot contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_byte_vld | input | 1 | One-cycle strobe: a received byte is on `bus_byte` |
| bus_byte | input | 8 | Received byte, MSB first on the wire |
| apb_psel | input | 1 | APB select |
| apb_penable | input | 1 | APB access phase |
| apb_pwrite | input | 1 | APB write when 1 |
| apb_paddr | input | PADDR_W (8) | APB byte address |
| apb_pwdata | input | PDATA_W (32) | APB write data |
| apb_prdata | output | PDATA_W (32) | APB read data, valid while selected |
| hit_any | output | 1 | At least one slot hit in the current frame |

## Verification
Two pairs of events can collide. A START can arrive in the same cycle as a byte strobe. A software write to a slot can complete in the same cycle as the byte that is compared against that slot. The bench drives both collisions directly, and it also injects START-with-byte at random at the head of random frames. For the START collision it then sends a further byte that would hit only if it were taken as the frame's first byte. The outcome of that byte shows whether the colliding byte was dropped. For the write collision, a bench model applies the compare before the write, and the hit bitmap is compared with that model. The slot is also read back to confirm that the write itself took effect.

// File: rtl/i2c_afilt_pkg.sv
package i2c_afilt_pkg;

   localparam int HITMAP_OFS    = 128;
   localparam int FILT_BASE_OFS = 136;
   localparam int FILT_STRIDE   = 4;
   localparam int EN_BIT        = 15;
   localparam int TEN_BIT       = 14;
   localparam int SLOT_ADDR_W   = 10;
   localparam logic [4:0] TEN_PREFIX = 5'b11110;

   typedef struct packed {
      logic                   en;
      logic                   ten;
      logic [SLOT_ADDR_W-1:0] addr;
   } afilt_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SECOND,
      ST_REST
   } frame_st_t;

endpackage

// File: rtl/i2c_afilt_regs.sv
module i2c_afilt_regs
   import i2c_afilt_pkg::*;
#(
   parameter int NUM_FILT   = 4,
   parameter int PADDR_W    = 8,
   parameter int PDATA_W    = 32,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           psel,
   input  logic                           penable,
   input  logic                           pwrite,
   input  logic [PADDR_W-1:0]             paddr,
   input  logic [PDATA_W-1:0]             pwdata,
   input  logic [NUM_FILT-1:0]            hit_map,
   output logic [PDATA_W-1:0]             prdata,
   output afilt_cfg_t [NUM_FILT-1:0]      cfg
);

   localparam logic [PADDR_W-1:0] HIT_ADDR = PADDR_W'(HITMAP_OFS);

   logic                                  wr_en;
   logic [NUM_FILT-1:0]                   wr_sel;
   logic [NUM_FILT-1:0][PADDR_W-1:0]      slot_addr;
   logic [NUM_FILT-1:0]                   en_q;
   logic [NUM_FILT-1:0]                   ten_q;
   logic [NUM_FILT-1:0][SLOT_ADDR_W-1:0]  addr_q;
   logic                                  unused_wdata;

   assign wr_en        = psel & penable & pwrite;
   assign unused_wdata = ^{pwdata[PDATA_W-1:EN_BIT+1], pwdata[TEN_BIT-1:SLOT_ADDR_W]};

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_dec
      assign slot_addr[i] = PADDR_W'(FILT_BASE_OFS + FILT_STRIDE * i);
      assign wr_sel[i]    = wr_en && (paddr == slot_addr[i]);
      assign cfg[i]       = '{en: en_q[i], ten: ten_q[i], addr: addr_q[i]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         addr_q <= '0;
      end else begin
         for (int i = 0; i < NUM_FILT; i++) begin
            if (wr_sel[i]) begin
               en_q[i]   <= pwdata[EN_BIT];
               addr_q[i] <= pwdata[SLOT_ADDR_W-1:0];
            end
         end
      end
   end

   if (TEN_BIT_EN) begin : g_ten_store
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ten_q <= '0;
         end else begin
            for (int i = 0; i < NUM_FILT; i++) begin
               if (wr_sel[i]) ten_q[i] <= pwdata[TEN_BIT];
            end
         end
      end
   end else begin : g_ten_none
      assign ten_q = '0;
   end

   always_comb begin
      prdata = '0;
      if (psel && !pwrite) begin
         if (paddr == HIT_ADDR) prdata = PDATA_W'(hit_map);
         for (int i = 0; i < NUM_FILT; i++) begin
            if (paddr == slot_addr[i])
               prdata = PDATA_W'({en_q[i], ten_q[i], 4'b0000, addr_q[i]});
         end
      end
   end

endmodule

// File: rtl/i2c_afilt_seq.sv
module i2c_afilt_seq
   import i2c_afilt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic byte_vld,
   output logic first_stb,
   output logic second_stb
);

   frame_st_t st_q;
   frame_st_t st_d;
   logic      take;

   assign take       = byte_vld & ~start;
   assign first_stb  = take && (st_q == ST_FIRST);
   assign second_stb = take && (st_q == ST_SECOND);

   always_comb begin
      st_d = st_q;
      if (start) begin
         st_d = ST_FIRST;
      end else if (byte_vld) begin
         case (st_q)
            ST_FIRST:  st_d = ST_SECOND;
            ST_SECOND: st_d = ST_REST;
            default:   st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/i2c_afilt_slice.sv
module i2c_afilt_slice
   import i2c_afilt_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       first_stb,
   input  logic       second_stb,
   input  logic [7:0] rx_byte,
   input  afilt_cfg_t cfg,
   output logic       hit
);

   logic match7;
   logic tail_ok;

   assign match7 = cfg.en && !cfg.ten && (rx_byte[7:1] == cfg.addr[6:0]);

   if (TEN_BIT_EN) begin : g_ten
      logic pend_q;
      logic head_ok;

      assign head_ok = cfg.en && cfg.ten &&
                       (rx_byte[7:3] == TEN_PREFIX) &&
                       (rx_byte[2:1] == cfg.addr[9:8]);
      assign tail_ok = pend_q && cfg.en && (rx_byte == cfg.addr[7:0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_q <= 1'b0;
         else if (start)      pend_q <= 1'b0;
         else if (first_stb)  pend_q <= head_ok;
         else if (second_stb) pend_q <= 1'b0;
      end
   end else begin : g_seven_only
      assign tail_ok = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     hit <= 1'b0;
      else if (start)                 hit <= 1'b0;
      else if (first_stb)             hit <= match7;
      else if (second_stb && tail_ok) hit <= 1'b1;
   end

endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
   import i2c_afilt_pkg::*;
#(
   parameter int NUM_FILT   = 4,
   parameter int PADDR_W    = 8,
   parameter int PDATA_W    = 32,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_start,
   input  logic               bus_byte_vld,
   input  logic [7:0]         bus_byte,
   input  logic               apb_psel,
   input  logic               apb_penable,
   input  logic               apb_pwrite,
   input  logic [PADDR_W-1:0] apb_paddr,
   input  logic [PDATA_W-1:0] apb_pwdata,
   output logic [PDATA_W-1:0] apb_prdata,
   output logic               hit_any
);

   if (NUM_FILT < 1 || NUM_FILT > 16) begin : g_bad_nfilt
      $error("NUM_FILT must lie in 1..16");
   end
   if (FILT_BASE_OFS + FILT_STRIDE * NUM_FILT > (1 << PADDR_W)) begin : g_bad_paddr
      $error("PADDR_W too narrow for the slot window");
   end
   if (PDATA_W < 16 || PDATA_W < NUM_FILT) begin : g_bad_pdata
      $error("PDATA_W must hold a slot word and the bitmap");
   end

   afilt_cfg_t [NUM_FILT-1:0] cfg;
   logic [NUM_FILT-1:0]       hit_q;
   logic [NUM_FILT-1:0]       filt_en;
   logic                      first_stb;
   logic                      second_stb;

   i2c_afilt_regs #(
      .NUM_FILT   (NUM_FILT),
      .PADDR_W    (PADDR_W),
      .PDATA_W    (PDATA_W),
      .TEN_BIT_EN (TEN_BIT_EN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .psel    (apb_psel),
      .penable (apb_penable),
      .pwrite  (apb_pwrite),
      .paddr   (apb_paddr),
      .pwdata  (apb_pwdata),
      .hit_map (hit_q),
      .prdata  (apb_prdata),
      .cfg     (cfg)
   );

   i2c_afilt_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (bus_start),
      .byte_vld   (bus_byte_vld),
      .first_stb  (first_stb),
      .second_stb (second_stb)
   );

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_slot
      assign filt_en[i] = cfg[i].en;

      i2c_afilt_slice #(
         .TEN_BIT_EN (TEN_BIT_EN)
      ) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (bus_start),
         .first_stb  (first_stb),
         .second_stb (second_stb),
         .rx_byte    (bus_byte),
         .cfg        (cfg[i]),
         .hit        (hit_q[i])
      );
   end

   assign hit_any = |hit_q;

endmodule

// File: rtl/i2c_afilt_chk.sv
module i2c_afilt_chk #(
   parameter int NUM_FILT = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                byte_vld,
   input logic                hit_any,
   input logic [NUM_FILT-1:0] hit_map,
   input logic [NUM_FILT-1:0] filt_en
);

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (hit_map == '0)); // R8

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !byte_vld) |=> $stable(hit_map)); // R9

   AST_NO_MIDFRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((~hit_map & $past(hit_map)) == '0)); // R8

   AST_ANY_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_any) |-> ($past(byte_vld) && !$past(start))); // R10

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_en
      AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hit_map[i]) |-> $past(filt_en[i])); // R7
   end

endmodule

bind i2c_addr_filter i2c_afilt_chk #(.NUM_FILT(NUM_FILT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (bus_start),
   .byte_vld (bus_byte_vld),
   .hit_any  (hit_any),
   .hit_map  (hit_q),
   .filt_en  (filt_en)
);

// File: tb/tb_i2c_addr_filter.sv
module tb_i2c_addr_filter;

   localparam int CLK_PERIOD = 10;
   localparam int NF = 4;
   localparam int PA = 8;
   localparam int PD = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_start = 1'b0;
   logic          bus_byte_vld = 1'b0;
   logic [7:0]    bus_byte = '0;
   logic          apb_psel = 1'b0;
   logic          apb_penable = 1'b0;
   logic          apb_pwrite = 1'b0;
   logic [PA-1:0] apb_paddr = '0;
   logic [PD-1:0] apb_pwdata = '0;
   logic [PD-1:0] apb_prdata;
   logic          hit_any;

   i2c_addr_filter #(.NUM_FILT(NF), .PADDR_W(PA), .PDATA_W(PD)) dut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_byte_vld(bus_byte_vld),
      .bus_byte(bus_byte), .apb_psel(apb_psel), .apb_penable(apb_penable),
      .apb_pwrite(apb_pwrite), .apb_paddr(apb_paddr), .apb_pwdata(apb_pwdata),
      .apb_prdata(apb_prdata), .hit_any(hit_any)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model built from the requirements
   logic [NF-1:0] m_en = '0, m_ten = '0, m_pend = '0, m_hits = '0;
   logic [9:0]    m_addr [NF];
   int            m_stage = 0;

   task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic m_start();
      m_stage = 1; m_pend = '0; m_hits = '0;
   endtask

   task automatic m_byte(logic [7:0] b);
      if (m_stage == 1) begin
         for (int i = 0; i < NF; i++) begin
            if (m_en[i] && !m_ten[i] && b[7:1] == m_addr[i][6:0]) m_hits[i] = 1'b1;
            m_pend[i] = m_en[i] && m_ten[i] && b[7:3] == 5'b11110 && b[2:1] == m_addr[i][9:8];
         end
         m_stage = 2;
      end else if (m_stage == 2) begin
         for (int i = 0; i < NF; i++)
            if (m_pend[i] && m_en[i] && b == m_addr[i][7:0]) m_hits[i] = 1'b1;
         m_pend = '0;
         m_stage = 3;
      end
   endtask

   task automatic m_write(logic [7:0] a, logic [31:0] d);
      for (int i = 0; i < NF; i++) begin
         if (a == 8'(136 + 4*i)) begin
            m_en[i] = d[15]; m_ten[i] = d[14]; m_addr[i] = d[9:0];
         end
      end
   endtask

   function automatic logic [31:0] slot_word(int i);
      return {16'h0, m_en[i], m_ten[i], 4'b0000, m_addr[i]};
   endfunction

   task automatic apb_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      apb_psel = 1'b1; apb_pwrite = 1'b1; apb_paddr = a; apb_pwdata = d; apb_penable = 1'b0;
      @(negedge clk);
      apb_penable = 1'b1;
      @(negedge clk);
      apb_psel = 1'b0; apb_penable = 1'b0; apb_pwrite = 1'b0;
      m_write(a, d);
   endtask

   task automatic write_with_byte(logic [7:0] a, logic [31:0] d, logic [7:0] b);
      @(negedge clk);
      apb_psel = 1'b1; apb_pwrite = 1'b1; apb_paddr = a; apb_pwdata = d; apb_penable = 1'b0;
      @(negedge clk);
      apb_penable = 1'b1; bus_byte_vld = 1'b1; bus_byte = b;
      @(negedge clk);
      apb_psel = 1'b0; apb_penable = 1'b0; apb_pwrite = 1'b0; bus_byte_vld = 1'b0;
      m_byte(b);
      m_write(a, d);
   endtask

   task automatic apb_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      apb_psel = 1'b1; apb_pwrite = 1'b0; apb_paddr = a;
      #1 d = apb_prdata;
      @(negedge clk);
      apb_psel = 1'b0;
   endtask

   task automatic send_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
      m_start();
   endtask

   task automatic send_start_with_byte(logic [7:0] b);
      @(negedge clk); bus_start = 1'b1; bus_byte_vld = 1'b1; bus_byte = b;
      @(negedge clk); bus_start = 1'b0; bus_byte_vld = 1'b0;
      m_start();
   endtask

   task automatic send_byte(logic [7:0] b);
      @(negedge clk); bus_byte_vld = 1'b1; bus_byte = b;
      @(negedge clk); bus_byte_vld = 1'b0;
      m_byte(b);
   endtask

   task automatic check_hits(string req);
      logic [31:0] d;
      apb_read(8'd128, d);
      check_eq(req, d, 32'(m_hits));
      check_eq({req, " R10 hit_any"}, 32'(hit_any), 32'(|m_hits));
   endtask

   task automatic check_slot(string req, int i);
      logic [31:0] d;
      apb_read(8'(136 + 4*i), d);
      check_eq(req, d, slot_word(i));
   endtask

   function automatic logic [9:0] pool_addr(int k);
      case (k)
         0: return 10'h063;
         1: return 10'h123;
         2: return 10'h079;
         3: return 10'h3C5;
         default: return 10'h001;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      for (int i = 0; i < NF; i++) m_addr[i] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check_hits("R1 reset bitmap");
      for (int i = 0; i < NF; i++) check_slot("R1 reset slot", i);

      // R2 program and read back, junk bits dropped
      apb_write(8'd144, 32'hFFFF_8063);   // slot 2, 7-bit 0x63
      apb_write(8'd140, 32'h0000_C123);   // slot 1, 10-bit 0x123
      apb_write(8'd148, 32'hFFFF_3C7A);   // slot 3, disabled
      check_slot("R2 slot2", 2);
      check_slot("R2 slot1", 1);
      check_slot("R2 slot3", 3);

      // R9 bytes before the first START are ignored
      send_byte(8'hC6);
      send_byte(8'h23);
      check_hits("R9 pre-start bytes");

      // R4 7-bit match, read/write bit ignored
      send_start(); send_byte(8'hC6);
      check_hits("R4 7-bit write");
      send_start(); send_byte(8'hC7);
      check_hits("R4 7-bit read");

      // R5 10-bit two-byte match
      send_start(); send_byte(8'hF3);
      check_hits("R5 first byte only");
      send_byte(8'h23);
      check_hits("R5 10-bit hit");

      // R6 misses
      send_start(); send_byte(8'hF3); send_byte(8'h54);
      check_hits("R6 10-bit tail miss");
      send_start(); send_byte(8'h13);
      check_hits("R6 7-bit miss");

      // R9 bytes after the second are ignored; R8 START clears
      send_start(); send_byte(8'hF3); send_byte(8'h23); send_byte(8'h00); send_byte(8'hC6);
      check_hits("R9 trailing bytes");
      send_start();
      check_hits("R8 start clears");

      // R7 disabled slot never hits
      apb_write(8'd144, 32'h0000_0063);
      send_start(); send_byte(8'hC6);
      check_hits("R7 disabled slot");
      apb_write(8'd144, 32'h0000_8063);

      // R8 START wins over a same-cycle byte
      send_start(); send_byte(8'hC6);
      check_hits("R8 setup hit");
      send_start_with_byte(8'hC6);
      check_hits("R8 collision clears");
      send_byte(8'h11);
      send_byte(8'hC6);
      check_hits("R8 colliding byte dropped");

      // R3 bitmap not writable
      send_start(); send_byte(8'hC6);
      apb_write(8'd128, 32'hFFFF_FFFF);
      check_hits("R3 write to bitmap ignored");

      // R11 compare uses the pre-write slot contents
      send_start();
      write_with_byte(8'd144, 32'h0000_0063, 8'hC6);
      check_hits("R11 old enable used");
      check_slot("R11 write landed", 2);
      send_start();
      write_with_byte(8'd136, 32'h0000_8055, 8'hAA);
      check_hits("R11 old disable used");
      check_slot("R11 write landed", 0);

      // random frames
      for (int f = 0; f < 300; f++) begin
         int nb;
         int j;
         if ($urandom % 4 == 0) begin
            int s = $urandom % NF;
            logic [31:0] w;
            w = {$urandom} & 32'hFFFF_3C00;
            w[15] = ($urandom % 4) != 0;
            w[14] = $urandom % 2;
            w[9:0] = pool_addr($urandom % 5);
            apb_write(8'(136 + 4*s), w);
         end
         if ($urandom % 8 == 0) send_start_with_byte(8'($urandom));
         else                   send_start();
         nb = 1 + $urandom % 3;
         j = $urandom % NF;
         for (int k = 0; k < nb; k++) begin
            logic [7:0] b;
            if ($urandom % 4 != 0) begin
               if (m_ten[j])
                  b = (k == 0) ? {5'b11110, m_addr[j][9:8], 1'($urandom)}
                               : (m_addr[j][7:0] ^ (($urandom % 3 == 0) ? 8'h01 : 8'h00));
               else
                  b = {m_addr[j][6:0], 1'($urandom)};
            end else begin
               b = 8'($urandom);
            end
            send_byte(b);
         end
         check_hits("R4 R5 R6 R7 random frame");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule